// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time as four BCD fields: tenths of a second, seconds, minutes and a 12-hour hours field that carries an afternoon (PM) flag. It runs from a mains-derived tick input. A prescaler turns 50 Hz or 60 Hz ticks into a 10 Hz advance of the tenths digit. Every digit carry ripples through to the hours in the same advance. A second set of four registers holds an alarm time. On every advance the new time is compared with the alarm, and a full match produces a one-cycle pulse for a downstream interrupt controller.

Software reaches the block through a byte bus with four addresses, one per field. A steering input selects whether writes go to the running clock or to the alarm set. Reads always return the clock. Software can read all four fields as one consistent value. Reading the hours field freezes a snapshot of the whole time, and reading the tenths field releases it. The counter keeps running while the snapshot is held.

Top module: `tod_clock`

## Requirements
- R1: With `mains_50hz`=1 the tenths field advances on the first tick after reset and then on every 5th tick. With `mains_50hz`=0 it advances on the first tick and then on every 6th tick.
- R2: Tenths count 0..9, and 9 wraps to 0 with a carry into seconds. Seconds and minutes count BCD 00..59, and 59 wraps to 00 with a carry into the next field.
- R3: Hours use bit 7 as the PM flag, bit 4 as the tens digit and bits 3:0 as the units digit. 09 steps to 10. 11 steps to 00 and inverts the PM flag. Any other hour keeps its PM flag.
- R4: A single advance carries through every field, so 11:59:59.9 becomes 00:00:00.0 with the PM flag inverted in one step.
- R5: Address 0 is tenths, 1 is seconds, 2 is minutes and 3 is hours. Written bytes are masked to 0x0F, 0x7F, 0x7F and 0x9F respectively.
- R6: While `alarm_sel`=1, writes load the alarm fields and leave the clock unchanged. While it is 0, writes load the clock.
- R7: `alarm_pulse` is high for exactly one cycle, in the cycle after an advancing tick edge, when the new time equals the alarm time in all four fields.
- R8: A read of address 3 freezes the read data of all four fields at the current time, and counting continues underneath. A read of address 0 returns the frozen tenths and then releases the freeze. After the release, reads show the live time.
- R9: Synchronous reset clears all clock fields, all alarm fields, the prescaler and the freeze. `alarm_pulse` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mains_tick | input | 1 | One-cycle pulse per mains period |
| mains_50hz | input | 1 | 1: divide ticks by 5; 0: divide by 6 |
| alarm_sel | input | 1 | 1: writes go to alarm fields; 0: to clock |
| bus_addr | input | 2 | Field select (0 tenths, 1 sec, 2 min, 3 hours) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives freeze/release) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed clock field |
| alarm_pulse | output | 1 | One-cycle alarm match event |

## Verification
The hardest case to reach from the ports is the noon/midnight wrap. Starting from reset, it needs 432,000 tenths advances, which is far more than a short run allows. The bench writes the clock to one tenth before each hour boundary, for all 24 combinations of hour and PM flag, and then applies a single tick. A continuous run from 11:55:00.0 through the wrap shows that the carry chain also works without a preset. Alarm and freeze behaviour is reached by counting ticks from reset, where the prescaler phase is known.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam logic [7:0] TENTHS_MASK = 8'h0F;
    localparam logic [7:0] SEXA_MASK   = 8'h7F;
    localparam logic [7:0] HOUR_MASK   = 8'h9F;

    typedef enum logic [1:0] {
        FLD_TENTHS = 2'd0,
        FLD_SEC    = 2'd1,
        FLD_MIN    = 2'd2,
        FLD_HOUR   = 2'd3
    } tod_field_e;

    typedef struct packed {
        logic [7:0] hr;
        logic [6:0] mn;
        logic [6:0] sc;
        logic [3:0] tn;
    } tod_time_t;

    typedef struct packed {
        logic       carry;
        logic [6:0] val;
    } step_t;

    function automatic step_t tenths_inc(input logic [3:0] t);
        logic [4:0] n;
        step_t r;
        n = {1'b0, t} + 5'd1;
        if (n > 5'd9) begin
            r.val   = 7'd0;
            r.carry = 1'b1;
        end else begin
            r.val   = {3'b000, n[3:0]};
            r.carry = 1'b0;
        end
        return r;
    endfunction

    function automatic step_t bcd60_inc(input logic [6:0] v);
        logic [4:0] lo;
        logic [3:0] hi;
        step_t r;
        lo = {1'b0, v[3:0]} + 5'd1;
        hi = {1'b0, v[6:4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 4'd1;
        end
        if (hi > 4'd5) begin
            r.val   = 7'd0;
            r.carry = 1'b1;
        end else begin
            r.val   = {hi[2:0], lo[3:0]};
            r.carry = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] hour_inc(input logic [7:0] h);
        logic [4:0] lo;
        logic [1:0] hi;
        logic [5:0] sum;
        lo = {1'b0, h[3:0]} + 5'd1;
        hi = {1'b0, h[4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 2'd1;
        end
        sum = {hi, lo[3:0]};
        if (sum > 6'h11)
            return {~h[7], 7'd0};
        return {h[7], 2'b00, sum[4:0]};
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int TICKS_50 = 5,
    parameter int TICKS_60 = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sel_50,
    output logic advance
);
    localparam int MAX_N = (TICKS_50 > TICKS_60) ? TICKS_50 : TICKS_60;
    localparam int DIV_W = (MAX_N > 2) ? $clog2(MAX_N) : 1;
    localparam logic [DIV_W-1:0] RELOAD_50 = DIV_W'(TICKS_50 - 1);
    localparam logic [DIV_W-1:0] RELOAD_60 = DIV_W'(TICKS_60 - 1);
    localparam logic [DIV_W-1:0] DIV_TOP   = DIV_W'(MAX_N - 1);

    logic [DIV_W-1:0] div_q;

    assign advance = tick && (div_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            if (div_q == '0)
                div_q <= sel_50 ? RELOAD_50 : RELOAD_60;
            else
                div_q <= div_q - 1'b1;
        end
    end

    // R1
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        div_q <= DIV_TOP);

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      advance,
    input  logic      wr_clk,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output tod_time_t now_q,
    output logic      stepped_q
);
    tod_time_t nxt;
    step_t     t_step, s_step, m_step;

    always_comb begin
        nxt    = now_q;
        t_step = tenths_inc(now_q.tn);
        s_step = bcd60_inc(now_q.sc);
        m_step = bcd60_inc(now_q.mn);
        if (advance) begin
            nxt.tn = t_step.val[3:0];
            if (t_step.carry) begin
                nxt.sc = s_step.val;
                if (s_step.carry) begin
                    nxt.mn = m_step.val;
                    if (m_step.carry)
                        nxt.hr = hour_inc(now_q.hr);
                end
            end
        end
        if (wr_clk) begin
            case (tod_field_e'(addr))
                FLD_TENTHS: nxt.tn = wdata[3:0] & TENTHS_MASK[3:0];
                FLD_SEC:    nxt.sc = wdata[6:0] & SEXA_MASK[6:0];
                FLD_MIN:    nxt.mn = wdata[6:0] & SEXA_MASK[6:0];
                FLD_HOUR:   nxt.hr = wdata & HOUR_MASK;
                default:    nxt = now_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q     <= '0;
            stepped_q <= 1'b0;
        end else begin
            now_q     <= nxt;
            stepped_q <= advance;
        end
    end

    // R2
    tenths_range_chk: assert property (@(posedge clk) disable iff (rst)
        (stepped_q && !$past(wr_clk)) |-> (now_q.tn <= 4'd9));

    // R4
    full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stepped_q && !$past(wr_clk) && $past(now_q.hr[4:0]) == 5'h11 &&
         $past(now_q.mn) == 7'h59 && $past(now_q.sc) == 7'h59 &&
         $past(now_q.tn) == 4'h9)
        |-> (now_q == {~$past(now_q.hr[7]), 7'd0, 7'd0, 7'd0, 4'd0}));

    // R5
    hour_mask_chk: assert property (@(posedge clk) disable iff (rst)
        now_q.hr[6:5] == 2'b00);

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_alm,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       stepped,
    input  tod_time_t  now,
    output logic       pulse
);
    tod_time_t alm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
        end else if (wr_alm) begin
            case (tod_field_e'(addr))
                FLD_TENTHS: alm_q.tn <= wdata[3:0] & TENTHS_MASK[3:0];
                FLD_SEC:    alm_q.sc <= wdata[6:0] & SEXA_MASK[6:0];
                FLD_MIN:    alm_q.mn <= wdata[6:0] & SEXA_MASK[6:0];
                FLD_HOUR:   alm_q.hr <= wdata & HOUR_MASK;
                default:    alm_q <= alm_q;
            endcase
        end
    end

    assign pulse = stepped && (now == alm_q);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/tod_readout.sv
module tod_readout
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd,
    input  logic [1:0] addr,
    input  tod_time_t  now,
    output logic [7:0] rdata
);
    tod_time_t snap_q;
    tod_time_t view;
    logic      frozen_q;
    logic      grab, drop;

    assign grab = rd && (tod_field_e'(addr) == FLD_HOUR) && !frozen_q;
    assign drop = rd && (tod_field_e'(addr) == FLD_TENTHS);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q   <= '0;
            frozen_q <= 1'b0;
        end else begin
            if (grab) begin
                snap_q   <= now;
                frozen_q <= 1'b1;
            end else if (drop) begin
                frozen_q <= 1'b0;
            end
        end
    end

    assign view = frozen_q ? snap_q : now;

    always_comb begin
        case (tod_field_e'(addr))
            FLD_TENTHS: rdata = {4'b0000, view.tn};
            FLD_SEC:    rdata = {1'b0, view.sc};
            FLD_MIN:    rdata = {1'b0, view.mn};
            default:    rdata = view.hr;
        endcase
    end

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && $past(frozen_q)) |-> $stable(snap_q));

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int TICKS_50 = 5,
    parameter int TICKS_60 = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mains_tick,
    input  logic       mains_50hz,
    input  logic       alarm_sel,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       alarm_pulse
);
    logic      advance;
    logic      stepped;
    tod_time_t now;
    logic      wr_clk, wr_alm;

    assign wr_clk = bus_wr && !alarm_sel;
    assign wr_alm = bus_wr && alarm_sel;

    tod_prescaler #(
        .TICKS_50(TICKS_50),
        .TICKS_60(TICKS_60)
    ) u_presc (
        .clk    (clk),
        .rst    (rst),
        .tick   (mains_tick),
        .sel_50 (mains_50hz),
        .advance(advance)
    );

    tod_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .wr_clk   (wr_clk),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .now_q    (now),
        .stepped_q(stepped)
    );

    tod_alarm u_alarm (
        .clk    (clk),
        .rst    (rst),
        .wr_alm (wr_alm),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .stepped(stepped),
        .now    (now),
        .pulse  (alarm_pulse)
    );

    tod_readout u_read (
        .clk  (clk),
        .rst  (rst),
        .rd   (bus_rd),
        .addr (bus_addr),
        .now  (now),
        .rdata(bus_rdata)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !alarm_pulse);

endmodule

// File: tb/tod_clock_tb.sv
module tod_clock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mains_tick = 1'b0;
    logic       mains_50hz = 1'b1;
    logic       alarm_sel = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       alarm_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int pulse_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_clock u_dut (
        .clk        (clk),
        .rst        (rst),
        .mains_tick (mains_tick),
        .mains_50hz (mains_50hz),
        .alarm_sel  (alarm_sel),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .alarm_pulse(alarm_pulse)
    );

    always @(negedge clk) if (!rst && alarm_pulse) pulse_cnt++;

    typedef struct packed {
        logic [7:0]  hr, mn, sc, tn;
        logic        m50;
        logic [15:0] nt;
        logic [7:0]  ehr, emn, esc, etn;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'd1,  8'h00, 8'h00, 8'h00, 8'h01},
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'd6,  8'h00, 8'h00, 8'h00, 8'h02},
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'd6,  8'h00, 8'h00, 8'h00, 8'h01},
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'd7,  8'h00, 8'h00, 8'h00, 8'h02},
        '{8'h00, 8'h00, 8'h59, 8'h09, 1'b1, 16'd1,  8'h00, 8'h01, 8'h00, 8'h00},
        '{8'h00, 8'h59, 8'h59, 8'h09, 1'b1, 16'd1,  8'h01, 8'h00, 8'h00, 8'h00},
        '{8'h09, 8'h59, 8'h59, 8'h09, 1'b1, 16'd1,  8'h10, 8'h00, 8'h00, 8'h00},
        '{8'h11, 8'h59, 8'h59, 8'h09, 1'b1, 16'd1,  8'h80, 8'h00, 8'h00, 8'h00},
        '{8'h91, 8'h59, 8'h59, 8'h09, 1'b1, 16'd1,  8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h00, 8'h00, 8'h19, 8'h09, 1'b1, 16'd1,  8'h00, 8'h00, 8'h20, 8'h00},
        '{8'h00, 8'h00, 8'h00, 8'h09, 1'b0, 16'd13, 8'h00, 8'h00, 8'h01, 8'h02},
        '{8'h89, 8'h59, 8'h59, 8'h09, 1'b1, 16'd1,  8'h90, 8'h00, 8'h00, 8'h00}
    };

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mains_tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; alarm_sel = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic to_alarm);
        @(negedge clk);
        alarm_sel = to_alarm; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; alarm_sel = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s, input logic [7:0] t);
        wr(2'd3, h, 1'b0);
        wr(2'd2, m, 1'b0);
        wr(2'd1, s, 1'b0);
        wr(2'd0, t, 1'b0);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        mains_tick = 1'b1;
        repeat (n) @(negedge clk);
        mains_tick = 1'b0;
    endtask

    task automatic check_time(input string tag, input logic [7:0] eh, input logic [7:0] em,
                              input logic [7:0] es, input logic [7:0] et);
        logic [7:0] h, m, s, t;
        rd(2'd3, h);
        rd(2'd2, m);
        rd(2'd1, s);
        rd(2'd0, t);
        check8({tag, " hours"}, h, eh);
        check8({tag, " minutes"}, m, em);
        check8({tag, " seconds"}, s, es);
        check8({tag, " tenths"}, t, et);
    endtask

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;

        // R9: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (alarm_pulse !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 pulse in reset: got %b expected 0", alarm_pulse);
        end
        rst = 1'b0;
        check_time("R9 reset", 8'h00, 8'h00, 8'h00, 8'h00);

        // R1 R2 R3 R4: table of presets, modes and tick counts
        for (int i = 0; i < NV; i++) begin
            do_reset();
            set_time(VEC[i].hr, VEC[i].mn, VEC[i].sc, VEC[i].tn);
            mains_50hz = VEC[i].m50;
            ticks(int'(VEC[i].nt));
            check_time($sformatf("R1/R2/R3/R4 vector %0d", i),
                       VEC[i].ehr, VEC[i].emn, VEC[i].esc, VEC[i].etn);
        end

        // R3: every hour boundary, both halves of the day
        for (int h = 0; h < 24; h++) begin
            int hv;
            logic pm;
            logic [7:0] start, exp;
            hv = h % 12;
            pm = (h >= 12);
            start = {pm, 7'(to_bcd(hv))};
            exp = (hv == 11) ? {~pm, 7'd0} : {pm, 7'(to_bcd(hv + 1))};
            do_reset();
            mains_50hz = 1'b1;
            set_time(start, 8'h59, 8'h59, 8'h09);
            ticks(1);
            check_time($sformatf("R3 hour step %02h", start), exp, 8'h00, 8'h00, 8'h00);
        end

        // R4: continuous run across the noon wrap from 11:55:00.0
        do_reset();
        mains_50hz = 1'b1;
        set_time(8'h11, 8'h55, 8'h00, 8'h00);
        ticks(14995);
        check_time("R4 long run before wrap", 8'h11, 8'h59, 8'h59, 8'h09);
        ticks(1);
        check_time("R4 long run after wrap", 8'h80, 8'h00, 8'h00, 8'h00);

        // R5: write masks per field
        do_reset();
        set_time(8'hFF, 8'hFF, 8'hFF, 8'hFF);
        check_time("R5 masks", 8'h9F, 8'h7F, 8'h7F, 8'h0F);

        // R6 R7: alarm steering and single match pulse
        do_reset();
        mains_50hz = 1'b1;
        wr(2'd0, 8'h03, 1'b1);
        rd(2'd0, v);
        check8("R6 clock untouched by alarm write", v, 8'h00);
        base = pulse_cnt;
        ticks(1);
        @(negedge clk);
        check8("R7 no pulse at .1", 8'(pulse_cnt - base), 8'd0);
        ticks(5);
        @(negedge clk);
        check8("R7 no pulse at .2", 8'(pulse_cnt - base), 8'd0);
        ticks(5);
        @(negedge clk);
        check8("R7 one pulse at .3", 8'(pulse_cnt - base), 8'd1);
        ticks(5);
        @(negedge clk);
        check8("R7 no pulse at .4", 8'(pulse_cnt - base), 8'd1);

        // R8: freeze on hours read, release on tenths read
        do_reset();
        mains_50hz = 1'b1;
        rd(2'd3, v);
        check8("R8 hours at freeze", v, 8'h00);
        ticks(11);
        rd(2'd1, v);
        check8("R8 frozen seconds", v, 8'h00);
        rd(2'd0, v);
        check8("R8 frozen tenths", v, 8'h00);
        rd(2'd0, v);
        check8("R8 live tenths after release", v, 8'h03);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule